// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Interrupt Flags

The block is a 16-bit free-running counter that advances on a divided bus clock, plus two byte-wide registers on a small read/write bus. The control register does two jobs. Its upper nibble enables interrupts, one bit per event. Its two low bits select the clock divider. The status register latches four timer events: counter wrap, a real-time tick, an accumulator overflow and an accumulator input edge. Software clears a latched event by writing a one to its bit. A single registered interrupt line is raised while any latched event has its enable bit set.

The real-time tick and the two accumulator events come from outside the block as one-cycle pulses. In normal mode the control register is protected: it takes one write, and only within a short window after reset. In special mode it can be rewritten at any time. The counter value is brought out on its own port.

Top module: `tmr_prescaled_irq`

## Requirements
- R1: When the counter steps from 0xFFFF to 0x0000, status bit 7 is set on that same clock edge.
- R2: Control bits [1:0] select the divider, with 00 = /1, 01 = /4, 10 = /8 and 11 = /16. The counter advances exactly once per divided period and holds between periods.
- R3: A one-cycle pulse on `rt_evt`, `acc_ovf_evt` or `acc_edge_evt` sets status bit 6, 5 or 4 respectively on the next edge.
- R4: In normal mode (`special_mode`=0) the control register accepts only its first write, and only if that write falls in the first 64 cycles after reset. Any later write leaves it unchanged. In special mode every write is accepted.
- R5: A write to the status register (`bus_addr`=1) clears each bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: Control bits [3:2] and status bits [3:0] always read 0, whatever is written to them.
- R7: After reset both registers read 0x00, the divider is /1 and `irq` is low.
- R8: `irq` equals the OR over bits 7..4 of (status AND control), delayed by one register stage.
- R9: If an event sets a status bit in the same cycle that a write clears that bit, the bit ends up set.
- R10: A change of the divider select restarts the divider. The first count after the change comes one full new period after the restart, and the restart happens one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | 1 = control register writable at any time |
| bus_wr | input | 1 | Write strobe for the register addressed by `bus_addr` |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rt_evt | input | 1 | Real-time tick pulse |
| acc_ovf_evt | input | 1 | Accumulator overflow pulse |
| acc_edge_evt | input | 1 | Accumulator input-edge pulse |
| count | output | 16 | Current counter value |
| irq | output | 1 | Registered interrupt request |

## Verification
Two things can hit the same status bit in one cycle: an event setting it, and a software write-one clearing it. The bench produces this by raising the accumulator-edge pulse on the very edge that writes 0x10 to the status register. It then expects bit 4 to still read as set, while a plain clear with no event present is seen to drop the bit. A second overlap is a divider-select write landing while the old divided period is still running. This is judged by checking that the counter stays put for exactly four edges after the restart and then steps once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned N_EVT  = 4;
   localparam int unsigned EVT_LO = REG_W - N_EVT;
   localparam logic SEL_CTRL = 1'b0;
   localparam logic SEL_STAT = 1'b1;
   localparam logic [REG_W-1:0] CTRL_IMPL = 8'hF3;

   typedef enum logic [1:0] {
      DIV1  = 2'b00,
      DIV4  = 2'b01,
      DIV8  = 2'b10,
      DIV16 = 2'b11
   } div_sel_e;

   function automatic int unsigned div_limit(div_sel_e s);
      case (s)
         DIV1:    return 0;
         DIV4:    return 3;
         DIV8:    return 7;
         default: return 15;
      endcase
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  div_sel_e         sel,
   output logic             tick,
   output logic             wrap,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (PRE_W < 4) begin : g_bad_pre
      $error("PRE_W too narrow for divide by 16");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   div_sel_e         sel_d;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;
   logic             restart;

   assign lim     = PRE_W'(div_limit(sel));
   assign restart = (sel != sel_d);
   assign tick    = !restart && (pre_q == lim);
   assign wrap    = tick && (count == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_d <= DIV1;
         pre_q <= '0;
         count <= '0;
      end else begin
         sel_d <= sel;
         if (restart || tick) pre_q <= '0;
         else                 pre_q <= pre_q + 1'b1;
         if (tick) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
   import tmr_pkg::*;
#(
   parameter int unsigned WIN_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special_mode,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctrl,
   output logic             win_closed
);
   localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);
   localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_CYCLES);

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("WIN_CYCLES must be positive");
   end

   logic [WIN_W-1:0] cyc_q;
   logic             used_q;
   logic             accept;

   assign win_closed = used_q || (cyc_q == WIN_END);
   assign accept     = wr && (special_mode || !win_closed);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         used_q <= 1'b0;
         ctrl   <= '0;
      end else begin
         if (cyc_q != WIN_END) cyc_q <= cyc_q + 1'b1;
         if (accept) begin
            ctrl <= wdata & CTRL_IMPL;
            if (!special_mode) used_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
   import tmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] set,
   input  logic             clr_wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] flags
);
   logic [N_EVT-1:0] flg_q;
   logic [N_EVT-1:0] clr;

   assign clr   = {N_EVT{clr_wr}} & wdata[REG_W-1:EVT_LO];
   assign flags = {flg_q, {EVT_LO{1'b0}}};

   for (genvar i = 0; i < N_EVT; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       flg_q[i] <= 1'b0;
         else if (set[i])  flg_q[i] <= 1'b1;
         else if (clr[i])  flg_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_prescaled_irq.sv
module tmr_prescaled_irq
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned WIN_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special_mode,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic             rt_evt,
   input  logic             acc_ovf_evt,
   input  logic             acc_edge_evt,
   output logic [CNT_W-1:0] count,
   output logic             irq
);
   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] flag_q;
   logic             tick_w;
   logic             wrap_w;
   logic             win_closed_w;
   logic [N_EVT-1:0] evt_set;
   logic             irq_d;

   tmr_ctrl_reg #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .special_mode (special_mode),
      .wr           (bus_wr && (bus_addr == SEL_CTRL)),
      .wdata        (bus_wdata),
      .ctrl         (ctrl_q),
      .win_closed   (win_closed_w)
   );

   tmr_prescaler #(.CNT_W(CNT_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (div_sel_e'(ctrl_q[1:0])),
      .tick  (tick_w),
      .wrap  (wrap_w),
      .count (count)
   );

   assign evt_set = {wrap_w, rt_evt, acc_ovf_evt, acc_edge_evt};

   tmr_flag_reg u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (evt_set),
      .clr_wr (bus_wr && (bus_addr == SEL_STAT)),
      .wdata  (bus_wdata),
      .flags  (flag_q)
   );

   assign irq_d     = |(flag_q[REG_W-1:EVT_LO] & ctrl_q[REG_W-1:EVT_LO]);
   assign bus_rdata = (bus_addr == SEL_STAT) ? flag_q : ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_d;
   end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             special_mode,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic [REG_W-1:0] bus_wdata,
   input logic             rt_evt,
   input logic             acc_ovf_evt,
   input logic             acc_edge_evt,
   input logic             tick,
   input logic             wrap,
   input logic [CNT_W-1:0] count,
   input logic [REG_W-1:0] ctrl,
   input logic [REG_W-1:0] flags,
   input logic             win_closed,
   input logic             irq
);
   assert_wrap_sets_ovf_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flags[7]);

   assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   assert_rt_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rt_evt |=> flags[6]);

   assert_locked_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && win_closed) |=> $stable(ctrl));

   assert_zero_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SEL_STAT && bus_wdata == '0 && !wrap && !rt_evt
       && !acc_ovf_evt && !acc_edge_evt) |=> $stable(flags));

   assert_irq_registered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(flags[7:4] & ctrl[7:4])));

   assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_edge_evt && bus_wr && bus_addr == SEL_STAT && bus_wdata[4]) |=> flags[4]);
endmodule

bind tmr_prescaled_irq tmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .special_mode (special_mode),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .rt_evt       (rt_evt),
   .acc_ovf_evt  (acc_ovf_evt),
   .acc_edge_evt (acc_edge_evt),
   .tick         (tick_w),
   .wrap         (wrap_w),
   .count        (count),
   .ctrl         (ctrl_q),
   .flags        (flag_q),
   .win_closed   (win_closed_w),
   .irq          (irq)
);

// File: tb/tb_tmr_prescaled_irq.sv
module tb_tmr_prescaled_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rt_evt = 1'b0;
   logic        acc_ovf_evt = 1'b0;
   logic        acc_edge_evt = 1'b0;
   logic [15:0] count;
   logic        irq;

   always #5 clk = ~clk;

   tmr_prescaled_irq dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rt_evt(rt_evt), .acc_ovf_evt(acc_ovf_evt),
      .acc_edge_evt(acc_edge_evt), .count(count), .irq(irq)
   );

   // what: 0 = control reg, 1 = status reg, 2 = irq, 3 = count
   typedef struct {
      string       req;
      int unsigned what;
      logic [15:0] exp;
   } item_t;

   item_t exp_q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 0;

   // monitor: compares at the falling edge, away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         item_t       it;
         logic [15:0] act;
         it = exp_q.pop_front();
         case (it.what)
            0, 1:    act = {8'h00, bus_rdata};
            2:       act = {15'h0, irq};
            default: act = count;
         endcase
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: obs %0d actual 0x%0h expected 0x%0h",
                     it.req, it.what, act, it.exp);
         end
      end
   end

   task automatic push(input string req, input int unsigned what, input logic [15:0] exp);
      item_t it;
      it.req = req; it.what = what; it.exp = exp;
      if (what == 0) bus_addr = 1'b0;
      if (what == 1) bus_addr = 1'b1;
      exp_q.push_back(it);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      logic [15:0] c;
      repeat (3) step();
      rst_n = 1'b1;
      // R7: reset state
      push("R7 ctrl reset", 0, 16'h00); step();
      push("R7 status reset", 1, 16'h00); push("R7 irq reset", 2, 16'h0);
      c = count;
      repeat (5) step();
      push("R2 divide by 1", 3, c + 16'd5); step();

      // R4/R6: first write in window accepted, unimplemented bits dropped
      reg_write(1'b0, 8'hFE);
      push("R6 ctrl bits 3:2 read zero", 0, 16'hF2); step();
      reg_write(1'b0, 8'h00);
      push("R4 second normal write ignored", 0, 16'hF2);
      step(); step();
      c = count;
      repeat (16) step();
      push("R2 divide by 8 over 16 cycles", 3, c + 16'd2); step();

      // R3/R8: real-time event, registered irq
      rt_evt = 1'b1; step(); rt_evt = 1'b0;
      push("R3 rt event latched", 1, 16'h40); push("R8 irq lags a cycle", 2, 16'h0);
      step();
      push("R8 irq raised", 2, 16'h1); step();
      reg_write(1'b1, 8'h00);
      push("R5 zero write keeps flag", 1, 16'h40); step();
      reg_write(1'b1, 8'h8F);
      push("R6 low status bits read zero", 1, 16'h40); step();
      reg_write(1'b1, 8'h40);
      push("R5 write one clears", 1, 16'h00);
      step();
      push("R8 irq dropped", 2, 16'h0); step();

      // R9: set and clear collide
      acc_edge_evt = 1'b1; step(); acc_edge_evt = 1'b0;
      push("R3 acc edge latched", 1, 16'h10); step();
      acc_edge_evt = 1'b1; reg_write(1'b1, 8'h10); acc_edge_evt = 1'b0;
      push("R9 set wins over clear", 1, 16'h10); step();
      acc_ovf_evt = 1'b1; step(); acc_ovf_evt = 1'b0;
      push("R3 acc ovf latched", 1, 16'h30); step();
      reg_write(1'b1, 8'h30);
      push("R5 both cleared", 1, 16'h00); step();

      // R4 special mode rewrites; R10 divider restart
      special_mode = 1'b1;
      reg_write(1'b0, 8'h81);
      c = count;
      push("R4 special write accepted", 0, 16'h81);
      repeat (4) step();
      push("R10 no count during restart period", 3, c);
      step();
      push("R10 first count after restart", 3, c + 16'd1); step();

      // R1: wrap at divide by 1
      reg_write(1'b0, 8'h80);
      while (count != 16'hFFFF) step();
      step();
      push("R1 wrap to zero", 3, 16'h0000); push("R1 ovf flag set", 1, 16'h80);
      step();
      push("R8 irq from ovf", 2, 16'h1); step();
      reg_write(1'b1, 8'h80);
      step();

      // R4: window expiry in normal mode
      special_mode = 1'b0;
      rst_n = 1'b0; step(); step(); rst_n = 1'b1;
      repeat (70) step();
      reg_write(1'b0, 8'hF3);
      push("R4 write after window ignored", 0, 16'h00); step();
      push("R7 irq stays low", 2, 16'h0); step();
      step();
      done = 1;
      summary();
   end
endmodule